// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Controller

This block is the control plane for a small in-order pipeline with fetch, decode, execute and write-back stages. It does not hold any data. It keeps the valid bit of the instruction in each pipeline register. Each cycle it reads the decoded source and destination fields of the decode and execute stages, the branch information in decode and the branch outcome in execute. From these it drives the load enables of the stage registers, the fetch request, the program-counter load and select, the forwarding selects of the two ALU operands, and a squash pulse.

The datapath loads the decode register from fetch when `d_load` is high, and the execute register from decode when `e_load` is high. The write-back register loads every cycle. The controller decides which of those loads carry a live instruction. A stalled or squashed slot becomes a bubble because its valid bit is cleared. The register-file write enable is only ever issued for a valid instruction in write-back.

The register file is assumed to pass a write through to a read in the same cycle. For that reason, only the execute stage can conflict with a decode-stage read. With forwarding built in, the execute-stage ALU result is captured into the operand latch while the dependent instruction moves from decode to execute. Without forwarding, decode holds instead. Branches are predicted in decode and resolved in execute.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, `d_vld`, `e_vld`, `w_vld`, `rf_we` and `f_req` are 0. `f_req` rises at the first clock edge after release.
- R2: With no hazard, a fetched instruction (`fetch_ok`=1) becomes valid in decode, execute and write-back on three consecutive edges.
- R3: In a cycle with `fetch_ok`=0 and decode not held, `pc_ld` is 0 and a bubble enters decode.
- R4: With forwarding disabled (`FWD_EN`=0), a decode operand in use whose register equals a valid, writing, nonzero execute destination holds decode and fetch (`d_load`=0, `pc_ld`=0). A bubble enters execute, and the hold lifts once execute no longer holds that producer.
- R5: With forwarding enabled, the same condition raises `fwd_a` (for `d_rs1`) or `fwd_b` (for `d_rs2`) and causes no hold.
- R6: No forwarding select and no hold is raised when the execute destination is register 0, when the execute instruction does not write, or when the operand is not in use.
- R7: A valid execute instruction flagged `e_multi` occupies execute for two cycles. In the first cycle `e_load`=0, `d_load`=0 and `pc_ld`=0, and a bubble enters write-back. In the second cycle it proceeds.
- R8: With `PRED_MODE`=0 every branch is predicted not taken: `pc_sel` stays 00 (sequential) for a branch in decode.
- R9: With `PRED_MODE`=1 a branch is predicted taken when `d_hint_vld`=1 and `d_hint_tk`=1. When `d_hint_vld`=0 it is predicted taken when `d_back`=1 (negative offset). A taken prediction for an advancing branch drives `pc_sel`=01 with `pc_ld`=1 and discards the instruction fetched in that cycle.
- R10: When a branch in execute resolves against its prediction, `squash`=1 and `pc_ld`=1. `pc_sel` is 10 (branch target) if the branch was taken and 11 (fall-through) if it was not. The decode instruction and the one being fetched are discarded, and fetch resumes on the next cycle.
- R11: `rf_we` is high only for a valid write-back instruction with `w_wr`=1. A squashed instruction never produces `rf_we`.

Ports, in the order of the top module's port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_ok | input | 1 | Instruction memory returns an instruction this cycle (0 on a miss) |
| d_rs1 | input | REG_AW | Decode source register A |
| d_rs2 | input | REG_AW | Decode source register B |
| d_use1 | input | 1 | Decode instruction reads source A |
| d_use2 | input | 1 | Decode instruction reads source B |
| d_is_br | input | 1 | Decode instruction is a conditional branch |
| d_back | input | 1 | Branch offset is negative (target below the branch) |
| d_hint_vld | input | 1 | Branch carries a prediction hint |
| d_hint_tk | input | 1 | Hint value: predict taken |
| e_rd | input | REG_AW | Execute destination register |
| e_wr | input | 1 | Execute instruction writes a register |
| e_multi | input | 1 | Execute instruction needs two execute cycles |
| e_br_taken | input | 1 | Resolved outcome of the branch in execute |
| w_wr | input | 1 | Write-back instruction writes a register |
| f_req | output | 1 | Fetch request |
| pc_ld | output | 1 | Program counter loads its next value |
| pc_sel | output | 2 | Next PC: 00 sequential, 01 predicted target, 10 resolved target, 11 fall-through |
| d_load | output | 1 | Decode register loads from fetch |
| e_load | output | 1 | Execute register loads from decode |
| d_vld | output | 1 | Decode slot holds a live instruction |
| e_vld | output | 1 | Execute slot holds a live instruction |
| w_vld | output | 1 | Write-back slot holds a live instruction |
| fwd_a | output | 1 | Operand A latch takes the ALU result |
| fwd_b | output | 1 | Operand B latch takes the ALU result |
| squash | output | 1 | Misprediction recovery this cycle |
| rf_we | output | 1 | Register-file write enable |

## Verification
The bench builds two copies of the controller side by side and drives them with the same stimulus. `u_dut` has forwarding and the offset/hint predictor (`FWD_EN`=1, `PRED_MODE`=1). `u_alt` has the stalling interlock and always-not-taken prediction (`FWD_EN`=0, `PRED_MODE`=0). Comparing the two on a single dependent pair shows forwarding and stalling against each other. Comparing them on one backward branch shows both prediction variants, including the fall-through recovery that only a taken prediction can cause. `REG_AW` stays at 5, which is enough to test the register-0 exclusion.

// File: rtl/phc_pkg.sv
package phc_pkg;
   typedef enum logic [1:0] {
      PC_SEQ      = 2'b00,
      PC_PRED     = 2'b01,
      PC_RESOLVED = 2'b10,
      PC_FALLTHRU = 2'b11
   } pc_sel_e;
endpackage

// File: rtl/phc_src_match.sv
module phc_src_match #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] dst,
   input  logic              use_src,
   output logic              hit
);
   assign hit = use_src && (src == dst);
endmodule

// File: rtl/phc_hazard.sv
module phc_hazard #(
   parameter int REG_AW = 5,
   parameter bit FWD_EN = 1'b1
) (
   input  logic                   d_vld,
   input  logic [1:0][REG_AW-1:0] src,
   input  logic [1:0]             use_src,
   input  logic                   e_vld,
   input  logic [REG_AW-1:0]      e_rd,
   input  logic                   e_wr,
   output logic [1:0]             fwd,
   output logic                   raw_stall
);
   localparam int N_SRC = 2;

   logic [N_SRC-1:0] hit;
   logic             live_dst;

   assign live_dst = d_vld && e_vld && e_wr && (e_rd != '0);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      phc_src_match #(.REG_AW(REG_AW)) u_match (
         .src    (src[i]),
         .dst    (e_rd),
         .use_src(use_src[i]),
         .hit    (hit[i])
      );
   end

   if (FWD_EN) begin : g_forward
      assign fwd       = live_dst ? hit : '0;
      assign raw_stall = 1'b0;
   end else begin : g_interlock
      assign fwd       = '0;
      assign raw_stall = live_dst && (|hit);
   end
endmodule

// File: rtl/phc_predict.sv
module phc_predict #(
   parameter int PRED_MODE = 1
) (
   input  logic is_br,
   input  logic back_off,
   input  logic hint_vld,
   input  logic hint_tk,
   output logic pred_tk
);
   if (PRED_MODE < 0 || PRED_MODE > 1) begin : g_bad_mode
      $error("phc_predict: PRED_MODE must be 0 or 1");
   end

   if (PRED_MODE == 0) begin : g_never
      logic unused_pred_in;
      assign unused_pred_in = ^{is_br, back_off, hint_vld, hint_tk};
      assign pred_tk = 1'b0;
   end else begin : g_backward
      assign pred_tk = is_br && (hint_vld ? hint_tk : back_off);
   end
endmodule

// File: rtl/phc_stage_ctl.sv
module phc_stage_ctl
   import phc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    fetch_ok,
   input  logic    raw_stall,
   input  logic    e_multi,
   input  logic    e_br_taken,
   input  logic    d_is_br,
   input  logic    d_pred_tk,
   output logic    f_req,
   output logic    pc_ld,
   output pc_sel_e pc_sel,
   output logic    d_load,
   output logic    e_load,
   output logic    d_vld,
   output logic    e_vld,
   output logic    w_vld,
   output logic    squash
);
   logic started;
   logic e_extra;
   logic e_br;
   logic e_pred;
   logic e_hold;
   logic d_hold;
   logic mispred;
   logic redirect;
   logic f_take;
   logic d_adv;

   assign e_hold   = e_vld && e_multi && !e_extra;
   assign d_hold   = d_vld && (e_hold || raw_stall);
   assign mispred  = e_vld && !e_hold && e_br && (e_br_taken != e_pred);
   assign d_adv    = d_vld && !d_hold && !mispred;
   assign redirect = d_adv && d_is_br && d_pred_tk;
   assign f_take   = started && fetch_ok && !d_hold;

   assign f_req  = started && !d_hold;
   assign pc_ld  = mispred || redirect || f_take;
   assign d_load = !d_hold;
   assign e_load = !e_hold;
   assign squash = mispred;

   always_comb begin
      if (mispred)       pc_sel = e_br_taken ? PC_RESOLVED : PC_FALLTHRU;
      else if (redirect) pc_sel = PC_PRED;
      else               pc_sel = PC_SEQ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         e_extra <= 1'b0;
         d_vld   <= 1'b0;
         e_vld   <= 1'b0;
         w_vld   <= 1'b0;
         e_br    <= 1'b0;
         e_pred  <= 1'b0;
      end else begin
         started <= 1'b1;
         e_extra <= e_hold;
         w_vld   <= e_vld && !e_hold;
         if (mispred)      d_vld <= 1'b0;
         else if (!d_hold) d_vld <= f_take && !redirect;
         if (!e_hold) begin
            e_vld  <= d_adv;
            e_br   <= d_adv && d_is_br;
            e_pred <= d_pred_tk;
         end
      end
   end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
   parameter int REG_AW    = 5,
   parameter bit FWD_EN    = 1'b1,
   parameter int PRED_MODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_ok,
   input  logic [REG_AW-1:0] d_rs1,
   input  logic [REG_AW-1:0] d_rs2,
   input  logic              d_use1,
   input  logic              d_use2,
   input  logic              d_is_br,
   input  logic              d_back,
   input  logic              d_hint_vld,
   input  logic              d_hint_tk,
   input  logic [REG_AW-1:0] e_rd,
   input  logic              e_wr,
   input  logic              e_multi,
   input  logic              e_br_taken,
   input  logic              w_wr,
   output logic              f_req,
   output logic              pc_ld,
   output logic [1:0]        pc_sel,
   output logic              d_load,
   output logic              e_load,
   output logic              d_vld,
   output logic              e_vld,
   output logic              w_vld,
   output logic              fwd_a,
   output logic              fwd_b,
   output logic              squash,
   output logic              rf_we
);
   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("pipe_hazard_ctl: REG_AW must lie in 1..8");
   end

   logic [1:0]       fwd;
   logic             raw_stall;
   logic             pred_tk;
   phc_pkg::pc_sel_e sel;

   phc_hazard #(.REG_AW(REG_AW), .FWD_EN(FWD_EN)) u_hazard (
      .d_vld    (d_vld),
      .src      ({d_rs2, d_rs1}),
      .use_src  ({d_use2, d_use1}),
      .e_vld    (e_vld),
      .e_rd     (e_rd),
      .e_wr     (e_wr),
      .fwd      (fwd),
      .raw_stall(raw_stall)
   );

   phc_predict #(.PRED_MODE(PRED_MODE)) u_predict (
      .is_br   (d_is_br),
      .back_off(d_back),
      .hint_vld(d_hint_vld),
      .hint_tk (d_hint_tk),
      .pred_tk (pred_tk)
   );

   phc_stage_ctl u_stages (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch_ok  (fetch_ok),
      .raw_stall (raw_stall),
      .e_multi   (e_multi),
      .e_br_taken(e_br_taken),
      .d_is_br   (d_is_br),
      .d_pred_tk (pred_tk),
      .f_req     (f_req),
      .pc_ld     (pc_ld),
      .pc_sel    (sel),
      .d_load    (d_load),
      .e_load    (e_load),
      .d_vld     (d_vld),
      .e_vld     (e_vld),
      .w_vld     (w_vld),
      .squash    (squash)
   );

   assign pc_sel = sel;
   assign fwd_a  = fwd[0];
   assign fwd_b  = fwd[1];
   assign rf_we  = w_vld && w_wr;
endmodule

// File: rtl/phc_checker.sv
module phc_checker (
   input logic clk,
   input logic rst_n,
   input logic fetch_ok,
   input logic f_req,
   input logic d_load,
   input logic e_load,
   input logic d_vld,
   input logic e_vld,
   input logic w_vld,
   input logic fwd_a,
   input logic fwd_b,
   input logic squash,
   input logic rf_we
);
   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!d_vld && !e_vld && !w_vld && !f_req)); // R1
   AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (e_vld && e_load) |=> w_vld); // R2
   AST_FETCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_ok && d_load) |=> !d_vld); // R3
   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!d_load && !squash) |=> (d_vld && $stable(d_vld))); // R4
   AST_FWD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      ((fwd_a || fwd_b) && e_load) |-> d_load); // R5
   AST_MULTI_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      !e_load |=> !w_vld); // R7
   AST_SQUASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> (!d_vld && !e_vld)); // R10
   AST_SQUASH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> ##1 !rf_we); // R11
endmodule

bind pipe_hazard_ctl phc_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fetch_ok(fetch_ok),
   .f_req   (f_req),
   .d_load  (d_load),
   .e_load  (e_load),
   .d_vld   (d_vld),
   .e_vld   (e_vld),
   .w_vld   (w_vld),
   .fwd_a   (fwd_a),
   .fwd_b   (fwd_b),
   .squash  (squash),
   .rf_we   (rf_we)
);

// File: tb/pipe_hazard_ctl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_tb;
   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fetch_ok, d_use1, d_use2, d_is_br, d_back, d_hint_vld, d_hint_tk;
   logic e_wr, e_multi, e_br_taken, w_wr;
   logic [AW-1:0] d_rs1, d_rs2, e_rd;

   logic a_freq, a_pcld, a_dld, a_eld, a_dv, a_ev, a_wv, a_fa, a_fb, a_sq, a_we;
   logic b_freq, b_pcld, b_dld, b_eld, b_dv, b_ev, b_wv, b_fa, b_fb, b_sq, b_we;
   logic [1:0] a_sel, b_sel;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   pipe_hazard_ctl #(.REG_AW(AW), .FWD_EN(1'b1), .PRED_MODE(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_ok(fetch_ok), .d_rs1(d_rs1), .d_rs2(d_rs2),
      .d_use1(d_use1), .d_use2(d_use2), .d_is_br(d_is_br), .d_back(d_back),
      .d_hint_vld(d_hint_vld), .d_hint_tk(d_hint_tk), .e_rd(e_rd), .e_wr(e_wr),
      .e_multi(e_multi), .e_br_taken(e_br_taken), .w_wr(w_wr),
      .f_req(a_freq), .pc_ld(a_pcld), .pc_sel(a_sel), .d_load(a_dld), .e_load(a_eld),
      .d_vld(a_dv), .e_vld(a_ev), .w_vld(a_wv), .fwd_a(a_fa), .fwd_b(a_fb),
      .squash(a_sq), .rf_we(a_we));

   pipe_hazard_ctl #(.REG_AW(AW), .FWD_EN(1'b0), .PRED_MODE(0)) u_alt (
      .clk(clk), .rst_n(rst_n), .fetch_ok(fetch_ok), .d_rs1(d_rs1), .d_rs2(d_rs2),
      .d_use1(d_use1), .d_use2(d_use2), .d_is_br(d_is_br), .d_back(d_back),
      .d_hint_vld(d_hint_vld), .d_hint_tk(d_hint_tk), .e_rd(e_rd), .e_wr(e_wr),
      .e_multi(e_multi), .e_br_taken(e_br_taken), .w_wr(w_wr),
      .f_req(b_freq), .pc_ld(b_pcld), .pc_sel(b_sel), .d_load(b_dld), .e_load(b_eld),
      .d_vld(b_dv), .e_vld(b_ev), .w_vld(b_wv), .fwd_a(b_fa), .fwd_b(b_fb),
      .squash(b_sq), .rf_we(b_we));

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_fields();
      fetch_ok = 1'b0; d_rs1 = '0; d_rs2 = '0; d_use1 = 1'b0; d_use2 = 1'b0;
      d_is_br = 1'b0; d_back = 1'b0; d_hint_vld = 1'b0; d_hint_tk = 1'b0;
      e_rd = '0; e_wr = 1'b0; e_multi = 1'b0; e_br_taken = 1'b0; w_wr = 1'b0;
   endtask

   // R1: reset state and first fetch timing
   task automatic do_reset();
      clear_fields();
      w_wr  = 1'b1;
      rst_n = 1'b0;
      tick(); tick();
      chk("R1 valids in reset", {1'b0, a_dv, a_ev, a_wv}, 4'h0);
      chk("R1 rf_we/f_req in reset", {2'b00, a_we, a_freq}, 4'h0);
      rst_n = 1'b1;
      #1;
      chk("R1 f_req low before first edge", {3'b000, a_freq}, 4'h0);
      tick();
      chk("R1 f_req after first edge", {3'b000, a_freq}, 4'h1);
      w_wr = 1'b0;
   endtask

   // R2, R3, R11: straight flow and fetch gap
   task automatic t_flow();
      do_reset();
      fetch_ok = 1'b1; w_wr = 1'b1; #1;
      chk("R2 pc_ld with fetch", {3'b000, a_pcld}, 4'h1);
      tick();
      chk("R2 decode valid", {1'b0, a_dv, a_ev, a_wv}, 4'h4);
      fetch_ok = 1'b0; #1;
      chk("R3 pc_ld low on miss", {3'b000, a_pcld}, 4'h0);
      tick();
      chk("R3 bubble into decode", {1'b0, a_dv, a_ev, a_wv}, 4'h2);
      tick();
      chk("R2 reaches write-back", {1'b0, a_dv, a_ev, a_wv}, 4'h1);
      chk("R11 rf_we for valid write", {3'b000, a_we}, 4'h1);
      tick();
      chk("R11 rf_we low for bubble", {3'b000, a_we}, 4'h0);
   endtask

   // R4, R5, R6: dependence on execute result
   task automatic t_raw();
      do_reset();
      fetch_ok = 1'b1;
      tick(); tick();
      e_rd = 5'd3; e_wr = 1'b1; d_rs1 = 5'd3; d_use1 = 1'b1; #1;
      chk("R5 fwd_a raised", {2'b00, a_fb, a_fa}, 4'h1);
      chk("R5 no hold with forwarding", {3'b000, a_dld}, 4'h1);
      chk("R4 interlock holds decode", {2'b00, b_dld, b_pcld}, 4'h0);
      chk("R4 no forward select", {2'b00, b_fb, b_fa}, 4'h0);
      tick();
      chk("R4 bubble into execute", {1'b0, b_dv, b_ev, b_wv}, 4'h5);
      chk("R4 hold lifts", {3'b000, b_dld}, 4'h1);
      chk("R5 forwarding pipe full", {1'b0, a_dv, a_ev, a_wv}, 4'h7);
      e_rd = 5'd0; d_rs1 = 5'd0; #1;
      chk("R6 register 0 never forwarded", {2'b00, a_fb, a_fa}, 4'h0);
      e_rd = 5'd3; d_rs1 = 5'd3; e_wr = 1'b0; #1;
      chk("R6 non-writing producer", {2'b00, a_fb, a_fa}, 4'h0);
      e_wr = 1'b1; d_use1 = 1'b0; #1;
      chk("R6 unused operand", {2'b00, a_fb, a_fa}, 4'h0);
      d_rs2 = 5'd3; d_use2 = 1'b1; #1;
      chk("R5 fwd_b raised", {2'b00, a_fb, a_fa}, 4'h2);
   endtask

   // R7: two-cycle execute
   task automatic t_multi();
      do_reset();
      fetch_ok = 1'b1;
      tick(); tick(); tick();
      e_multi = 1'b1; #1;
      chk("R7 first cycle holds", {1'b0, a_eld, a_dld, a_pcld}, 4'h0);
      tick();
      chk("R7 bubble into write-back", {1'b0, a_dv, a_ev, a_wv}, 4'h6);
      chk("R7 second cycle proceeds", {2'b00, a_eld, a_dld}, 4'h3);
      e_multi = 1'b0;
      tick();
      chk("R7 result reaches write-back", {3'b000, a_wv}, 4'h1);
   endtask

   // R10, R11: taken branch predicted not taken
   task automatic t_mispred();
      do_reset();
      fetch_ok = 1'b1;
      tick();
      d_is_br = 1'b1; d_back = 1'b0;
      tick();
      d_is_br = 1'b0; e_br_taken = 1'b1; #1;
      chk("R10 squash raised", {2'b00, a_sq, b_sq}, 4'h3);
      chk("R10 pc_sel target", {a_sel, a_pcld, 1'b0}, 4'b1010);
      tick();
      chk("R10 decode and execute cleared", {1'b0, a_dv, a_ev, a_wv}, 4'h1);
      e_br_taken = 1'b0; w_wr = 1'b1;
      tick();
      chk("R11 squashed slot writes nothing", {2'b00, a_we, b_we}, 4'h0);
      chk("R10 fetch resumed", {2'b00, a_dv, b_dv}, 4'h3);
   endtask

   // R8, R9, R10: backward branch, hints
   task automatic t_predict();
      do_reset();
      fetch_ok = 1'b1;
      tick();
      d_is_br = 1'b1; d_back = 1'b1; #1;
      chk("R9 backward predicted taken", {a_sel, a_pcld, 1'b0}, 4'b0110);
      chk("R8 static not-taken", {b_sel, 2'b00}, 4'h0);
      tick();
      chk("R9 fetched slot discarded", {2'b00, a_dv, a_ev}, 4'h1);
      chk("R8 sequential fetch kept", {2'b00, b_dv, b_ev}, 4'h3);
      d_is_br = 1'b0; e_br_taken = 1'b0; #1;
      chk("R10 fall-through recovery", {a_sel, a_sq, 1'b0}, 4'b1110);
      chk("R10 correct guess no squash", {2'b00, b_sel[0], b_sq}, 4'h0);
      do_reset();
      fetch_ok = 1'b1;
      tick();
      d_is_br = 1'b1; d_back = 1'b1; d_hint_vld = 1'b1; d_hint_tk = 1'b0; #1;
      chk("R9 hint overrides to not taken", {2'b00, a_sel}, 4'h0);
      d_back = 1'b0; d_hint_tk = 1'b1; #1;
      chk("R9 hint overrides to taken", {2'b00, a_sel}, 4'h1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      clear_fields();
      t_flow();
      t_raw();
      t_multi();
      t_mispred();
      t_predict();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule